// File: doc/BRIEF.md
# Keyed-Write Watchdog Register Interface

This block is the register front end of a watchdog timer, sitting on a simple synchronous peripheral bus. It holds three reset-control fields: an overflow flag, a reset-enable bit and a reset-select bit. It also holds a small up-counter that stands in for the watchdog count, so that the counter read path can be observed. The overflow flag is raised by a one-cycle pulse from the counting logic. Software can only lower it.

Writes to the reset-control fields go through one word-wide address, and the upper byte of the write acts as a key. One key value clears the overflow flag. Another key value loads the enable and select bits. No single write can do both. Byte-sized writes to that address are dropped, as are writes carrying any other key. Reads are byte reads, registered, and return the timer control byte, the counter or the reset-control byte, depending on the address.

Top module: `wdk_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the overflow flag, the enable bit and the select bit read 0, the counter reads 00h and the read data output is 00h.
- R2: A byte-sized write (bus_word=0) to the keyed address FF76h has no effect on any field. A write to any other address also has no effect on any field.
- R3: A word write to FF76h with data A500h clears the overflow flag. The enable and select bits keep their values.
- R4: A word write to FF76h whose upper byte is 5Ah loads the enable bit from bit 6 and the select bit from bit 5 of the lower byte. The overflow flag keeps its value, even when bit 7 of the lower byte is 1.
- R5: A word write to FF76h is ignored when its upper byte is neither A5h nor 5Ah. A word write with upper byte A5h and a lower byte other than 00h is also ignored.
- R6: A one-cycle pulse on ovf_pulse sets the overflow flag. When the pulse coincides with a valid clear write, the flag ends up set.
- R7: The read map is as follows. FF74h returns the control byte (parameter CTRL_VAL, default 18h). FF75h returns the counter. FF77h returns {overflow, enable, select, 11111b} with overflow at bit 7. The value of bus_word has no effect on a read.
- R8: Read data appears on bus_rdata on the clock after the read strobe and holds until the next read. A read of any other address, including FF76h, returns FFh.
- R9: The counter increments once for each cycle in which cnt_inc is high, and wraps from FFh to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data; upper byte carries the key on word writes |
| bus_word | input | 1 | 1 = word-sized access, 0 = byte-sized access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| ovf_pulse | input | 1 | One-cycle overflow event from the counting logic |
| cnt_inc | input | 1 | Counter increment enable |

## Verification
The hardest situation to reach from the ports is a valid clear write that lands in the same cycle as an overflow pulse. The bench drives both in one cycle through a single write task that takes the pulse as an argument, and then reads back the reset-control byte. The second hard case is a key write with a nonzero lower byte, such as A501h, which must leave the flag set. The bench reaches it only after the flag has first been raised by a pulse, so that the write has something to clear. The 5Ah write with bit 7 high is issued while the flag is low, so any path that lets software set the flag would show up in the next read.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] KEY_CLEAR = 8'hA5;
  localparam logic [7:0] KEY_LOAD  = 8'h5A;
  localparam logic [7:0] CLEAR_LOW = 8'h00;
  localparam int         ENA_BIT   = 6;
  localparam int         SEL_BIT   = 5;

  typedef struct packed {
    logic ovf;
    logic ena;
    logic sel;
  } rst_fields_t;
endpackage

// File: rtl/wdk_wdec.sv
module wdk_wdec #(
  parameter int               ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] WR_ADDR = 16'hFF76
) (
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic              clr_req,
  output logic              load_req,
  output logic              load_ena,
  output logic              load_sel
);
  import wdk_pkg::*;

  logic       hit;
  logic [7:0] key;
  logic [7:0] low;

  always_comb begin
    hit      = bus_wr && bus_word && (bus_addr == WR_ADDR);
    key      = bus_wdata[15:8];
    low      = bus_wdata[7:0];
    clr_req  = hit && (key == KEY_CLEAR) && (low == CLEAR_LOW);
    load_req = hit && (key == KEY_LOAD);
    load_ena = low[ENA_BIT];
    load_sel = low[SEL_BIT];
  end
endmodule

// File: rtl/wdk_rstctl.sv
module wdk_rstctl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_req,
  input  logic                 load_req,
  input  logic                 load_ena,
  input  logic                 load_sel,
  input  logic                 ovf_pulse,
  output wdk_pkg::rst_fields_t fields_q
);
  import wdk_pkg::*;

  rst_fields_t fields_d;
  logic        upd_en;

  always_comb begin
    fields_d = fields_q;
    if (load_req) begin
      fields_d.ena = load_ena;
      fields_d.sel = load_sel;
    end
    if (clr_req)   fields_d.ovf = 1'b0;
    if (ovf_pulse) fields_d.ovf = 1'b1;
    upd_en = load_req || clr_req || ovf_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fields_q <= '0;
    else if (upd_en) fields_q <= fields_d;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_inc,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdk_rdmux.sv
module wdk_rdmux #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF74,
  parameter logic [DATA_W-1:0] CTRL_VAL  = 8'h18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    cnt_val,
  input  wdk_pkg::rst_fields_t fields,
  output logic [DATA_W-1:0]    rdata_q
);
  localparam logic [ADDR_W-1:0] CNT_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RST_ADDR = BASE_ADDR + ADDR_W'(3);
  localparam int                FILL_W   = DATA_W - 3;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (bus_addr)
      BASE_ADDR: rdata_d = CTRL_VAL;
      CNT_ADDR:  rdata_d = cnt_val;
      RST_ADDR:  rdata_d = {fields.ovf, fields.ena, fields.sel, {FILL_W{1'b1}}};
      default:   rdata_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF74,
  parameter logic [DATA_W-1:0] CTRL_VAL  = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_word,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ovf_pulse,
  input  logic              cnt_inc
);
  import wdk_pkg::*;

  localparam logic [ADDR_W-1:0] WR_ADDR = BASE_ADDR + ADDR_W'(2);

  logic              clr_req, load_req, load_ena, load_sel;
  rst_fields_t       fields_q;
  logic              ovf_q, ena_q, sel_q;
  logic [DATA_W-1:0] cnt_q;

  wdk_wdec #(.ADDR_W(ADDR_W), .WR_ADDR(WR_ADDR)) u_wdec (
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .clr_req  (clr_req),
    .load_req (load_req),
    .load_ena (load_ena),
    .load_sel (load_sel)
  );

  wdk_rstctl u_rstctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_req  (clr_req),
    .load_req (load_req),
    .load_ena (load_ena),
    .load_sel (load_sel),
    .ovf_pulse(ovf_pulse),
    .fields_q (fields_q)
  );

  wdk_counter #(.CNT_W(DATA_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_inc(cnt_inc),
    .cnt_q  (cnt_q)
  );

  wdk_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .CTRL_VAL(CTRL_VAL)
  ) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .cnt_val (cnt_q),
    .fields  (fields_q),
    .rdata_q (bus_rdata)
  );

  always_comb begin
    ovf_q = fields_q.ovf;
    ena_q = fields_q.ena;
    sel_q = fields_q.sel;
  end
endmodule

// File: rtl/wdk_regs_chk.sv
module wdk_regs_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF74
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_word,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ovf_pulse,
  input logic              ovf_q,
  input logic              ena_q,
  input logic              sel_q
);
  localparam logic [ADDR_W-1:0] CNT_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WR_ADDR  = BASE_ADDR + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RST_ADDR = BASE_ADDR + ADDR_W'(3);

  logic key_wr, unmapped;
  always_comb begin
    key_wr   = bus_wr && bus_word && (bus_addr == WR_ADDR) && !ovf_pulse;
    unmapped = (bus_addr != BASE_ADDR) && (bus_addr != CNT_ADDR) && (bus_addr != RST_ADDR);
  end

  a_r2_byte_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_word && !ovf_pulse) |=> $stable({ovf_q, ena_q, sel_q}));

  a_r3_clear_keeps_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata == 16'hA500) |=> (!ovf_q && $stable({ena_q, sel_q})));

  a_r4_load_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata[15:8] == 8'h5A) |=>
      (ena_q == $past(bus_wdata[6]) && sel_q == $past(bus_wdata[5]) && $stable(ovf_q)));

  a_r6_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> ovf_q);

  a_r4_no_software_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_pulse && !ovf_q) |=> !ovf_q);

  a_r7_rst_byte_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == RST_ADDR) |=>
      (bus_rdata == {$past(ovf_q), $past(ena_q), $past(sel_q), {(DATA_W-3){1'b1}}}));

  a_r8_unmapped_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == '1));

  a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind wdk_regs wdk_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/wdk_regs_bench.sv
module wdk_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_word, bus_wr, bus_rd, ovf_pulse, cnt_inc;
  logic [7:0]  bus_rdata;

  int          applied = 0;
  int          bad     = 0;
  logic        m_ovf, m_ena, m_sel;
  logic [7:0]  m_cnt;
  logic        rd_q;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdk_regs u_wdk_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ovf_pulse(ovf_pulse), .cnt_inc(cnt_inc)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [15:0] a);
    case (a)
      16'hFF74: return 8'h18;
      16'hFF75: return m_cnt;
      16'hFF77: return {m_ovf, m_ena, m_sel, 5'b11111};
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; ovf_pulse = 0; cnt_inc = 0;
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [15:0] d, logic word, logic pulse);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = word; bus_wr = 1; ovf_pulse = pulse; bus_rd = 0;
    if (word && a == 16'hFF76) begin
      if (d == 16'hA500) m_ovf = 0;
      if (d[15:8] == 8'h5A) begin m_ena = d[6]; m_sel = d[5]; end
    end
    if (pulse) m_ovf = 1;
    idle(1);
  endtask

  task automatic do_read(logic [15:0] a, logic word, string req);
    @(negedge clk);
    bus_addr = a; bus_word = word; bus_rd = 1; bus_wr = 0; ovf_pulse = 0;
    exp_q.push_back(model_read(a));
    tag_q.push_back(req);
    idle(1);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_inc = 1; bus_wr = 0; bus_rd = 0;
      m_cnt = m_cnt + 8'd1;
    end
    idle(1);
  endtask

  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rst_n && rd_q) begin
      if (exp_q.size() == 0) begin
        applied++; bad++;
        $display("FAIL R8: got %02h expected no read data", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    applied++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_word = 0;
    bus_wr = 0; bus_rd = 0; ovf_pulse = 0; cnt_inc = 0;
    m_ovf = 0; m_ena = 0; m_sel = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1", bus_rdata, 8'h00);
    rst_n = 1;
    idle(1);
    check("R1", bus_rdata, 8'h00);
    do_read(16'hFF77, 0, "R1");
    do_read(16'hFF75, 0, "R1");
    do_read(16'hFF74, 0, "R7");
    do_write(16'hFF76, 16'h0000, 0, 1);
    do_read(16'hFF77, 0, "R6");
    do_write(16'hFF76, 16'h5AE0, 1, 0);
    do_read(16'hFF77, 0, "R4");
    do_write(16'hFF76, 16'hA500, 0, 0);
    do_read(16'hFF77, 0, "R2");
    do_write(16'hFF77, 16'hA500, 1, 0);
    do_write(16'hFF74, 16'h5A00, 1, 0);
    do_read(16'hFF77, 0, "R2");
    do_write(16'hFF76, 16'hA501, 1, 0);
    do_read(16'hFF77, 0, "R5");
    do_write(16'hFF76, 16'h3300, 1, 0);
    do_write(16'hFF76, 16'hA55A, 1, 0);
    do_read(16'hFF77, 0, "R5");
    do_write(16'hFF76, 16'hA500, 1, 0);
    do_read(16'hFF77, 0, "R3");
    do_write(16'hFF76, 16'h5A80, 1, 0);
    do_read(16'hFF77, 0, "R4");
    do_write(16'hFF76, 16'h5A40, 1, 0);
    do_read(16'hFF77, 0, "R4");
    do_write(16'hFF76, 16'hA500, 1, 1);
    do_read(16'hFF77, 0, "R6");
    tick(5);
    do_read(16'hFF75, 1, "R9");
    do_read(16'hFF75, 0, "R7");
    tick(251);
    do_read(16'hFF75, 0, "R9");
    do_read(16'hFF76, 0, "R8");
    do_read(16'hFF73, 1, "R8");
    do_read(16'hFF74, 1, "R7");
    idle(2);
    held = bus_rdata;
    tick(3);
    idle(3);
    check("R8", bus_rdata, held);
    idle(4);
    if (exp_q.size() != 0) begin
      applied++; bad++;
      $display("FAIL R8: got %0d pending reads expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule